// File: doc/BRIEF.md
# Electromagnetic Candidate Validation Selector

Every bunch crossing this block takes in a fixed set of calorimeter cluster candidates from the front-end cards. Each candidate has an 8-bit transverse energy, a 5-bit cluster address local to its card, the total energy seen on that card, and eight hit flags. Four of the flags come from the preshower cells behind the cluster and four from the pad detector cells behind it. A per-candidate enable marks which inputs carry data in the crossing.

The block classifies each candidate from its hit flags. A candidate with electromagnetic character and a charged track is an electron. One with electromagnetic character and no charge is a photon. The block then reports four maxima: the highest electron, the highest photon, the highest single-card total (local neutral pion), and the highest sum of two neighbouring candidates (global neutral pion). The two neutral-pion categories do not look at the hit flags.

Each report carries a valid flag, an 8-bit energy and an 8-bit address. The crossing identifier travels through the pipeline with its candidates. A downstream selection stage takes these as its inputs.

Top module: `em_cand_selector`

## Requirements
- R1: While reset is held, every output valid flag, energy, address and the crossing ID output are zero.
- R2: Hit flag bits [3:0] of a candidate are its preshower hits and bits [7:4] are its pad hits. A candidate is an electron when at least one preshower bit and at least one pad bit are set. It is a photon when at least one preshower bit is set and no pad bit is set. With no preshower bit set it is neither.
- R3: The electron output is the enabled electron with the highest energy. On equal energy the lower input index wins.
- R4: The photon output is the enabled photon with the highest energy. On equal energy the lower input index wins.
- R5: The local neutral-pion output carries the highest card total among all enabled candidates, whatever their hit flags. On equal totals the lower index wins, and the address is that candidate's.
- R6: The global neutral-pion output considers each neighbouring pair (i, i+1) in which both candidates are enabled. Its energy is et[i]+et[i+1], saturated at 255. It reports the pair with the highest sum, the lower pair wins ties, and the address is that of candidate i.
- R7: Every reported address is {input index[2:0], local cluster address[4:0]}.
- R8: Outputs appear two clock edges after their inputs are sampled. The crossing ID output is the crossing ID that was sampled with those inputs.
- R9: A category with no qualifying candidate reports its valid flag low, with energy and address zero.
- R10: A candidate whose enable is low does not affect any output, whatever its energy, totals or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_en | input | 8 | Per-candidate enable |
| cand_et | input | 64 | Candidate energies, 8 bits each, candidate i at [8i+7:8i] |
| cand_laddr | input | 40 | Local cluster addresses, 5 bits each |
| card_et | input | 64 | Card total energy behind each candidate, 8 bits each |
| cand_hits | input | 64 | Hit flags, 8 bits each (preshower low nibble, pad high nibble) |
| in_bxid | input | 8 | Bunch-crossing ID of the inputs |
| out_vld | output | 4 | Valid flag per category: 0 electron, 1 photon, 2 local pi0, 3 global pi0 |
| out_et | output | 32 | Energy per category, category c at [8c+7:8c] |
| out_addr | output | 32 | Address per category, category c at [8c+7:8c] |
| out_bxid | output | 8 | Crossing ID matching the outputs |

## Verification
Random crossings mix enables, energies and hit nibbles, so all four categories compete over sparse and dense candidate sets. Directed crossings cover the cases that random data seldom reaches. Equal energies at two indices separate a correct lower-index tie break from a reversed one. Pad-only hits show whether the classification wrongly treats charge without preshower as electromagnetic. A disabled candidate with the largest energy and electron flags shows whether the enable is honoured. A pair summing past 255 tells saturation apart from wrap-around, and an all-disabled crossing confirms the empty encoding.

// File: rtl/emsel_pkg.sv
package emsel_pkg;
  localparam int NUM_CAT = 4;
  typedef enum logic [1:0] {
    CAT_ELE = 2'd0,
    CAT_PHO = 2'd1,
    CAT_LOC = 2'd2,
    CAT_GLB = 2'd3
  } cat_e;
endpackage

// File: rtl/emsel_classify.sv
module emsel_classify #(
  parameter int HIT_W = 4
) (
  input  logic               en,
  input  logic [2*HIT_W-1:0] hits,
  output logic               is_ele,
  output logic               is_pho
);
  logic em_like;
  logic charged;

  always_comb begin
    em_like = |hits[HIT_W-1:0];
    charged = |hits[2*HIT_W-1:HIT_W];
    is_ele  = en & em_like & charged;
    is_pho  = en & em_like & ~charged;
  end
endmodule

// File: rtl/emsel_pair_sum.sv
module emsel_pair_sum #(
  parameter int ET_W = 8
) (
  input  logic            va,
  input  logic            vb,
  input  logic [ET_W-1:0] a,
  input  logic [ET_W-1:0] b,
  output logic            v,
  output logic [ET_W-1:0] sum
);
  logic [ET_W:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    sum = raw[ET_W] ? {ET_W{1'b1}} : raw[ET_W-1:0];
    v   = va & vb;
  end
endmodule

// File: rtl/emsel_max_tree.sv
module emsel_max_tree #(
  parameter int N  = 8,
  parameter int KW = 8,
  parameter int PW = 8,
  localparam int LV = (N > 1) ? $clog2(N) : 0,
  localparam int P  = 1 << LV
) (
  input  logic [N-1:0]    vld,
  input  logic [N*KW-1:0] key,
  input  logic [N*PW-1:0] pay,
  output logic            o_vld,
  output logic [KW-1:0]   o_key,
  output logic [PW-1:0]   o_pay
);
  logic [P-1:0]    vp;
  logic [P*KW-1:0] kp;
  logic [P*PW-1:0] pp;
  logic            nv [2*P-1];
  logic [KW-1:0]   nk [2*P-1];
  logic [PW-1:0]   np [2*P-1];

  assign vp = P'(vld);
  assign kp = (P*KW)'(key);
  assign pp = (P*PW)'(pay);

  // heap layout: leaves in index order, left child covers lower indices
  always_comb begin
    for (int i = 0; i < P; i++) begin
      nv[P-1+i] = vp[i];
      nk[P-1+i] = kp[i*KW +: KW];
      np[P-1+i] = pp[i*PW +: PW];
    end
    for (int k = P - 2; k >= 0; k--) begin
      if (nv[2*k+2] && (!nv[2*k+1] || (nk[2*k+2] > nk[2*k+1]))) begin
        nv[k] = nv[2*k+2];
        nk[k] = nk[2*k+2];
        np[k] = np[2*k+2];
      end else begin
        nv[k] = nv[2*k+1];
        nk[k] = nk[2*k+1];
        np[k] = np[2*k+1];
      end
    end
  end

  assign o_vld = nv[0];
  assign o_key = nk[0];
  assign o_pay = np[0];
endmodule

// File: rtl/em_cand_selector.sv
module em_cand_selector
  import emsel_pkg::*;
#(
  parameter int N_CAND  = 8,
  parameter int ET_W    = 8,
  parameter int LADDR_W = 5,
  parameter int HIT_W   = 4,
  parameter int BX_W    = 8,
  localparam int IDX_W  = $clog2(N_CAND),
  localparam int ADDR_W = IDX_W + LADDR_W,
  localparam int N_PAIR = N_CAND - 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_CAND-1:0]           cand_en,
  input  logic [N_CAND*ET_W-1:0]      cand_et,
  input  logic [N_CAND*LADDR_W-1:0]   cand_laddr,
  input  logic [N_CAND*ET_W-1:0]      card_et,
  input  logic [N_CAND*2*HIT_W-1:0]   cand_hits,
  input  logic [BX_W-1:0]             in_bxid,
  output logic [NUM_CAT-1:0]          out_vld,
  output logic [NUM_CAT*ET_W-1:0]     out_et,
  output logic [NUM_CAT*ADDR_W-1:0]   out_addr,
  output logic [BX_W-1:0]             out_bxid
);
  // classification and pair sums (combinational on inputs)
  logic [N_CAND-1:0]        c_ele, c_pho;
  logic [N_PAIR-1:0]        c_pv;
  logic [N_PAIR*ET_W-1:0]   c_psum;
  logic [N_CAND*ADDR_W-1:0] c_addr;

  for (genvar i = 0; i < N_CAND; i++) begin : g_cls
    emsel_classify #(.HIT_W(HIT_W)) u_cls (
      .en     (cand_en[i]),
      .hits   (cand_hits[i*2*HIT_W +: 2*HIT_W]),
      .is_ele (c_ele[i]),
      .is_pho (c_pho[i])
    );
    assign c_addr[i*ADDR_W +: ADDR_W] =
      {IDX_W'(i), cand_laddr[i*LADDR_W +: LADDR_W]};
  end

  for (genvar i = 0; i < N_PAIR; i++) begin : g_pair
    emsel_pair_sum #(.ET_W(ET_W)) u_pair (
      .va  (cand_en[i]),
      .vb  (cand_en[i+1]),
      .a   (cand_et[i*ET_W +: ET_W]),
      .b   (cand_et[(i+1)*ET_W +: ET_W]),
      .v   (c_pv[i]),
      .sum (c_psum[i*ET_W +: ET_W])
    );
  end

  // stage 1 registers
  logic [N_CAND-1:0]        s1_ele, s1_pho, s1_en;
  logic [N_CAND*ET_W-1:0]   s1_et, s1_tot;
  logic [N_CAND*ADDR_W-1:0] s1_addr;
  logic [N_PAIR-1:0]        s1_pv;
  logic [N_PAIR*ET_W-1:0]   s1_psum;
  logic [BX_W-1:0]          s1_bx;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_ele  <= '0;
      s1_pho  <= '0;
      s1_en   <= '0;
      s1_pv   <= '0;
      s1_bx   <= '0;
      s1_et   <= '0;
      s1_tot  <= '0;
      s1_addr <= '0;
      s1_psum <= '0;
    end else begin
      s1_ele  <= c_ele;
      s1_pho  <= c_pho;
      s1_en   <= cand_en;
      s1_pv   <= c_pv;
      s1_bx   <= in_bxid;
      s1_et   <= cand_et;
      s1_tot  <= card_et;
      s1_addr <= c_addr;
      s1_psum <= c_psum;
    end
  end

  // stage 2: one comparator tree per category
  logic              t_vld  [NUM_CAT];
  logic [ET_W-1:0]   t_key  [NUM_CAT];
  logic [ADDR_W-1:0] t_pay  [NUM_CAT];

  emsel_max_tree #(.N(N_CAND), .KW(ET_W), .PW(ADDR_W)) u_tree_ele (
    .vld(s1_ele), .key(s1_et), .pay(s1_addr),
    .o_vld(t_vld[CAT_ELE]), .o_key(t_key[CAT_ELE]), .o_pay(t_pay[CAT_ELE])
  );

  emsel_max_tree #(.N(N_CAND), .KW(ET_W), .PW(ADDR_W)) u_tree_pho (
    .vld(s1_pho), .key(s1_et), .pay(s1_addr),
    .o_vld(t_vld[CAT_PHO]), .o_key(t_key[CAT_PHO]), .o_pay(t_pay[CAT_PHO])
  );

  emsel_max_tree #(.N(N_CAND), .KW(ET_W), .PW(ADDR_W)) u_tree_loc (
    .vld(s1_en), .key(s1_tot), .pay(s1_addr),
    .o_vld(t_vld[CAT_LOC]), .o_key(t_key[CAT_LOC]), .o_pay(t_pay[CAT_LOC])
  );

  // pair i reports the address of its lower candidate i
  emsel_max_tree #(.N(N_PAIR), .KW(ET_W), .PW(ADDR_W)) u_tree_glb (
    .vld(s1_pv), .key(s1_psum), .pay(s1_addr[N_PAIR*ADDR_W-1:0]),
    .o_vld(t_vld[CAT_GLB]), .o_key(t_key[CAT_GLB]), .o_pay(t_pay[CAT_GLB])
  );

  // registered outputs, empty categories forced to zero
  for (genvar c = 0; c < NUM_CAT; c++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        out_vld[c]                   <= 1'b0;
        out_et[c*ET_W +: ET_W]       <= '0;
        out_addr[c*ADDR_W +: ADDR_W] <= '0;
      end else begin
        out_vld[c]                   <= t_vld[c];
        out_et[c*ET_W +: ET_W]       <= t_vld[c] ? t_key[c] : '0;
        out_addr[c*ADDR_W +: ADDR_W] <= t_vld[c] ? t_pay[c] : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_bxid <= '0;
    else     out_bxid <= s1_bx;
  end
endmodule

// File: rtl/emsel_chk.sv
module emsel_chk #(
  parameter int N_CAND  = 8,
  parameter int ET_W    = 8,
  parameter int LADDR_W = 5,
  parameter int HIT_W   = 4,
  parameter int BX_W    = 8,
  localparam int ADDR_W = $clog2(N_CAND) + LADDR_W
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_CAND-1:0]         cand_en,
  input logic [BX_W-1:0]           in_bxid,
  input logic [3:0]                out_vld,
  input logic [4*ET_W-1:0]         out_et,
  input logic [4*ADDR_W-1:0]       out_addr,
  input logic [BX_W-1:0]           out_bxid
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  for (genvar c = 0; c < 4; c++) begin : g_empty
    a_r9_empty_zero: assert property (@(posedge clk) disable iff (rst)
      !out_vld[c] |-> (out_et[c*ET_W +: ET_W] == '0 &&
                       out_addr[c*ADDR_W +: ADDR_W] == '0));
  end

  a_r8_bxid_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2) |-> (out_bxid == $past(in_bxid, 2)));

  a_r5_loc_present: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2) |-> (out_vld[2] == ($past(cand_en, 2) != '0)));

  a_r10_ele_needs_en: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2 && out_vld[0]) |-> ($past(cand_en, 2) != '0));

  a_r2_ele_pho_distinct: assert property (@(posedge clk) disable iff (rst)
    (out_vld[0] && out_vld[1]) |-> (out_addr[ADDR_W-1:0] != out_addr[2*ADDR_W-1:ADDR_W]));

  a_r6_glb_implies_loc: assert property (@(posedge clk) disable iff (rst)
    out_vld[3] |-> out_vld[2]);
endmodule

bind em_cand_selector emsel_chk #(
  .N_CAND(N_CAND), .ET_W(ET_W), .LADDR_W(LADDR_W), .HIT_W(HIT_W), .BX_W(BX_W)
) u_chk (
  .clk(clk), .rst(rst), .cand_en(cand_en), .in_bxid(in_bxid),
  .out_vld(out_vld), .out_et(out_et), .out_addr(out_addr), .out_bxid(out_bxid)
);

// File: tb/sim_em_cand_selector.sv
`timescale 1ns/1ps
module sim_em_cand_selector;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0]   cand_en;
  logic [N*8-1:0] cand_et;
  logic [N*5-1:0] cand_laddr;
  logic [N*8-1:0] card_et;
  logic [N*8-1:0] cand_hits;
  logic [7:0]     in_bxid;
  logic [3:0]     out_vld;
  logic [31:0]    out_et;
  logic [31:0]    out_addr;
  logic [7:0]     out_bxid;

  logic       b_en   [N];
  logic [7:0] b_et   [N];
  logic [4:0] b_la   [N];
  logic [7:0] b_tot  [N];
  logic [7:0] b_hit  [N];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int         e_vld  [4];
  logic [7:0] e_et   [4];
  logic [7:0] e_addr [4];

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cand_en[i]            = b_en[i];
      cand_et[i*8 +: 8]     = b_et[i];
      cand_laddr[i*5 +: 5]  = b_la[i];
      card_et[i*8 +: 8]     = b_tot[i];
      cand_hits[i*8 +: 8]   = b_hit[i];
    end
  end

  em_cand_selector u0 (
    .clk(clk), .rst(rst), .cand_en(cand_en), .cand_et(cand_et),
    .cand_laddr(cand_laddr), .card_et(card_et), .cand_hits(cand_hits),
    .in_bxid(in_bxid), .out_vld(out_vld), .out_et(out_et),
    .out_addr(out_addr), .out_bxid(out_bxid)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected outputs from the requirements
  task automatic compute();
    int best;
    int s;
    int bs;
    for (int c = 0; c < 4; c++) begin
      best = -1;
      bs = 0;
      for (int i = 0; i < N; i++) begin
        bit ps, pd, ok;
        int k;
        ps = |b_hit[i][3:0];
        pd = |b_hit[i][7:4];
        ok = 0;
        k = 0;
        case (c)
          0: begin ok = b_en[i] && ps && pd;  k = b_et[i];  end
          1: begin ok = b_en[i] && ps && !pd; k = b_et[i];  end
          2: begin ok = b_en[i];              k = b_tot[i]; end
          default: begin
            if (i < N - 1) begin
              ok = b_en[i] && b_en[i+1];
              s = b_et[i] + b_et[i+1];
              k = (s > 255) ? 255 : s;
            end
          end
        endcase
        if (ok && (best < 0 || k > bs)) begin
          best = i;
          bs = k;
        end
      end
      e_vld[c]  = (best >= 0);
      e_et[c]   = (best >= 0) ? 8'(bs) : 8'd0;
      e_addr[c] = (best >= 0) ? {3'(best), b_la[best]} : 8'd0;
    end
  endtask

  task automatic run_vec(string tag, logic [7:0] bx);
    string cr [4];
    cr[0] = "R3"; cr[1] = "R4"; cr[2] = "R5"; cr[3] = "R6";
    @(negedge clk);
    in_bxid = bx;
    compute();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      check({tag, " ", cr[c], " vld"}, int'(out_vld[c]), e_vld[c]);
      check({tag, " ", cr[c], " et"}, int'(out_et[c*8 +: 8]), int'(e_et[c]));
      check({tag, " R7 addr"}, int'(out_addr[c*8 +: 8]), int'(e_addr[c]));
    end
    check({tag, " R8 bxid"}, int'(out_bxid), int'(bx));
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      b_en[i] = 0; b_et[i] = 0; b_la[i] = 0; b_tot[i] = 0; b_hit[i] = 0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    clear_all();
    for (int i = 0; i < N; i++) begin
      b_en[i] = 1; b_et[i] = 8'd50 + 8'(i); b_hit[i] = 8'h11;
    end
    in_bxid = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 vld", int'(out_vld), 0);
    check("R1 et", int'(out_et), 0);
    check("R1 addr", int'(out_addr), 0);
    check("R1 bxid", int'(out_bxid), 0);
    rst = 1'b0;

    // R9: all candidates disabled, every category empty
    clear_all();
    run_vec("R9", 8'd1);

    // R3/R4 ties: lower index wins
    clear_all();
    b_en[2] = 1; b_et[2] = 100; b_la[2] = 5'd7;  b_hit[2] = 8'h21;
    b_en[5] = 1; b_et[5] = 100; b_la[5] = 5'd9;  b_hit[5] = 8'h81;
    b_en[3] = 1; b_et[3] = 77;  b_la[3] = 5'd1;  b_hit[3] = 8'h04;
    b_en[6] = 1; b_et[6] = 77;  b_la[6] = 5'd2;  b_hit[6] = 8'h08;
    b_tot[3] = 200; b_tot[6] = 200;
    run_vec("R3tie", 8'd2);

    // R2: pad hits without preshower are neither electron nor photon
    clear_all();
    b_en[1] = 1; b_et[1] = 250; b_hit[1] = 8'hF0;
    b_en[4] = 1; b_et[4] = 30;  b_hit[4] = 8'h10; b_la[4] = 5'd31;
    run_vec("R2", 8'd3);

    // R10: disabled candidate with biggest energy and electron flags ignored
    clear_all();
    b_en[0] = 0; b_et[0] = 255; b_tot[0] = 255; b_hit[0] = 8'hFF;
    b_en[1] = 1; b_et[1] = 40;  b_tot[1] = 60;  b_hit[1] = 8'h22; b_la[1] = 5'd3;
    b_en[7] = 1; b_et[7] = 90;  b_tot[7] = 10;  b_hit[7] = 8'h00; b_la[7] = 5'd17;
    run_vec("R10", 8'd4);

    // R6: saturation of a pair sum beyond 255
    clear_all();
    b_en[5] = 1; b_et[5] = 200;
    b_en[6] = 1; b_et[6] = 100; b_la[5] = 5'd12;
    b_en[0] = 1; b_et[0] = 120;
    b_en[1] = 1; b_et[1] = 130;
    run_vec("R6sat", 8'd5);

    // random crossings
    for (int v = 0; v < 300; v++) begin
      logic [7:0] mask;
      mask = 8'($urandom);
      for (int i = 0; i < N; i++) begin
        b_en[i]  = mask[i];
        b_et[i]  = (v % 4 == 0) ? 8'($urandom_range(0, 3) * 64) : 8'($urandom);
        b_la[i]  = 5'($urandom);
        b_tot[i] = 8'($urandom);
        b_hit[i] = 8'($urandom) & 8'($urandom);
      end
      run_vec("RND", 8'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule